// File: doc/BRIEF.md
# Delayed-Write Register File with Rollback

This block is a register file that can take back its most recent writes. A write does not go straight into the storage array. It first enters a short, address-tagged staging pipeline that is `DEPTH` stages long, where `DEPTH` matches the worst-case delay of an external error signal. Each cycle every staged entry moves one stage closer to the array. The entry that leaves the last stage is written into the array, but only if it is still marked valid. Every cycle shifts exactly one entry in. A cycle with no write shifts in an empty entry, so stage `i` always holds what happened `i+1` cycles ago.

Reads check the staging pipeline and the array in parallel. The newest valid staged write to the requested register wins over older staged writes and over the array. This makes every accepted write visible to readers in the cycle after it is presented.

When an error is reported late, the surrounding logic raises a rollback request with a count C. The block then invalidates the staged writes from the last C cycles. The registers then read exactly as they did C cycles earlier. Register 0 always reads as zero and cannot be written.

Top module: `drf_rollback_rf`

## Requirements
- R1: After reset every register reads zero on every read port.
- R2: A write with `wr_en` high, `rb_req` low and a nonzero `wr_addr` is returned by any read of that address from the following cycle on.
- R3: When several staged writes target the same register, a read returns the value of the most recent one.
- R4: A write that is not rolled back reaches the storage array `DEPTH+1` clock edges after it was accepted, and it then survives any later rollback.
- R5: A rollback request with count C (1 to `DEPTH`) discards the writes accepted in the last C cycles, so reads return the values of C cycles earlier.
- R6: A rollback count above `DEPTH` acts as `DEPTH`: every staged write is discarded.
- R7: A write presented in the same cycle as a rollback request is dropped.
- R8: Register 0 reads as zero on every port, and writes to it have no effect.
- R9: Each read port resolves its own address independently of the others.
- R10: A rollback with count 0 discards no earlier write. It still drops a write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | ADDR_W | Register written |
| wr_data | input | DATA_W | Value written |
| rb_req | input | 1 | Rollback request |
| rb_cnt | input | CNT_W | Number of cycles to undo; values above DEPTH saturate |
| rd_addr | input | RD_PORTS*ADDR_W | One register address per read port |
| rd_data | output | RD_PORTS*DATA_W | Combinational read result per port |

## Verification
A corrupted staging entry shows at the read ports in two ways. Forwarding may return a stale or wrong value in the cycle right after a write. Or, once the entry reaches the array `DEPTH+1` edges later, the value may be lost or land in the wrong register. A fault in the rollback mask appears only when a rollback is requested. After it, reads show either writes that should be gone or missing writes that should have stayed. The bench therefore reads two random addresses after every cycle of a random write/rollback mix. It also runs directed cases at counts 0, `DEPTH` and above `DEPTH`, and right at the commit boundary.

// File: rtl/drf_pkg.sv
package drf_pkg;
    localparam int DEF_DATA_W   = 16;
    localparam int DEF_ADDR_W   = 3;
    localparam int DEF_DEPTH    = 4;
    localparam int DEF_RD_PORTS = 2;
endpackage

// File: rtl/drf_stage.sv
module drf_stage #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          rb_req,
    input  logic [CNT_W-1:0]              rb_cnt,
    output logic [DEPTH-1:0]              ent_v,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_a,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_d,
    output logic                          cm_v,
    output logic [ADDR_W-1:0]             cm_a,
    output logic [DATA_W-1:0]             cm_d
);
    localparam int CW1 = CNT_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0]             v;
        logic [DEPTH-1:0][ADDR_W-1:0] a;
        logic [DEPTH-1:0][DATA_W-1:0] d;
    } stage_t;

    stage_t           st_d, st_q;
    logic [DEPTH-1:0] alive;
    logic [CW1-1:0]   cnt_eff;

    always_comb begin
        cnt_eff = ({1'b0, rb_cnt} > CW1'(DEPTH)) ? CW1'(DEPTH) : {1'b0, rb_cnt};
        for (int i = 0; i < DEPTH; i++) begin
            alive[i] = st_q.v[i] && !(rb_req && (cnt_eff > CW1'(i)));
        end
        cm_v = alive[DEPTH-1];
        cm_a = st_q.a[DEPTH-1];
        cm_d = st_q.d[DEPTH-1];

        st_d      = st_q;
        st_d.v[0] = wr_en && !rb_req && (wr_addr != '0);
        st_d.a[0] = wr_addr;
        st_d.d[0] = wr_data;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.v[i] = alive[i-1];
            st_d.a[i] = st_q.a[i-1];
            st_d.d[i] = st_q.d[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_v = st_q.v;
    assign ent_a = st_q.a;
    assign ent_d = st_q.d;

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rb_req && wr_addr != '0) |=> (st_q.v[0] && st_q.a[0] == $past(wr_addr)
                                                  && st_q.d[0] == $past(wr_data)));
    // R7
    rb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |=> !st_q.v[0]);
    // R6
    rb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && rb_cnt >= CNT_W'(DEPTH)) |=> (st_q.v == '0));

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift
            // R4
            shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (st_q.d[g] == $past(st_q.d[g-1]) && st_q.a[g] == $past(st_q.a[g-1])));
        end
    endgenerate
endmodule

// File: rtl/drf_lookup.sv
module drf_lookup #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int DEPTH  = 4
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [DEPTH-1:0]              ent_v,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_a,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_d,
    input  logic [DATA_W-1:0]             arr_val,
    output logic [DATA_W-1:0]             rd_data
);
    always_comb begin
        rd_data = arr_val;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_v[i] && ent_a[i] == rd_addr) rd_data = ent_d[i];
        end
        if (rd_addr == '0) rd_data = '0;
    end
endmodule

// File: rtl/drf_rollback_rf.sv
module drf_rollback_rf #(
    parameter int DATA_W   = drf_pkg::DEF_DATA_W,
    parameter int ADDR_W   = drf_pkg::DEF_ADDR_W,
    parameter int DEPTH    = drf_pkg::DEF_DEPTH,
    parameter int RD_PORTS = drf_pkg::DEF_RD_PORTS,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             rb_req,
    input  logic [CNT_W-1:0]                 rb_cnt,
    input  logic [RD_PORTS-1:0][ADDR_W-1:0]  rd_addr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data
);
    localparam int REGS = 1 << ADDR_W;

    logic [DEPTH-1:0]             ent_v;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_a;
    logic [DEPTH-1:0][DATA_W-1:0] ent_d;
    logic                         cm_v;
    logic [ADDR_W-1:0]            cm_a;
    logic [DATA_W-1:0]            cm_d;

    logic [REGS-1:0][DATA_W-1:0]  mem_d, mem_q;

    drf_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rb_req(rb_req), .rb_cnt(rb_cnt),
        .ent_v(ent_v), .ent_a(ent_a), .ent_d(ent_d),
        .cm_v(cm_v), .cm_a(cm_a), .cm_d(cm_d)
    );

    always_comb begin
        mem_d = mem_q;
        if (cm_v) mem_d[cm_a] = cm_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    generate
        for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
            drf_lookup #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_look (
                .rd_addr(rd_addr[p]),
                .ent_v(ent_v), .ent_a(ent_a), .ent_d(ent_d),
                .arr_val(mem_q[rd_addr[p]]),
                .rd_data(rd_data[p])
            );
            // R8
            zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_addr[p] == '0) |-> (rd_data[p] == '0));
        end
    endgenerate

    // R4
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_v |=> (mem_q[$past(cm_a)] == $past(cm_d)));
    // R8
    zero_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_q[0] == '0));
endmodule

// File: tb/sim_drf_rollback_rf.sv
module sim_drf_rollback_rf;
    localparam int DW = 16, AW = 3, N = 4, RP = 2, CW = $clog2(N + 1);
    localparam int REGS = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rb_req = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] rb_cnt = '0;
    logic [RP-1:0][AW-1:0] rd_addr = '0;
    logic [RP-1:0][DW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;

    bit          mv [N];
    bit [AW-1:0] ma [N];
    bit [DW-1:0] md [N];
    bit [DW-1:0] mem [REGS];

    always #5 clk = ~clk;

    drf_rollback_rf #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(N), .RD_PORTS(RP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rb_req(rb_req), .rb_cnt(rb_cnt), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic bit [DW-1:0] expect_rd(bit [AW-1:0] a);
        if (a == 0) return '0;
        for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return md[i];
        return mem[a];
    endfunction

    function automatic void model_step(bit we, bit [AW-1:0] wa, bit [DW-1:0] wd, bit rb, int rc);
        int c = (rc > N) ? N : rc;
        if (rb) for (int i = 0; i < c; i++) mv[i] = 1'b0;
        if (mv[N-1]) mem[ma[N-1]] = md[N-1];
        for (int i = N - 1; i > 0; i--) begin
            mv[i] = mv[i-1]; ma[i] = ma[i-1]; md[i] = md[i-1];
        end
        mv[0] = we && !rb && wa != 0; ma[0] = wa; md[0] = wd;
    endfunction

    task automatic cyc(bit we, bit [AW-1:0] wa, bit [DW-1:0] wd, bit rb, int rc);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rb_req = rb; rb_cnt = CW'(rc);
        @(posedge clk);
        #1;
        wr_en = 1'b0; rb_req = 1'b0;
        model_step(we, wa, wd, rb, rc);
    endtask

    task automatic chk(bit [AW-1:0] a0, bit [AW-1:0] a1, string tag);
        rd_addr[0] = a0; rd_addr[1] = a1;
        #1;
        n_chk++;
        if (rd_data[0] !== expect_rd(a0) || rd_data[1] !== expect_rd(a1)) begin
            n_fail++;
            $display("FAIL %s: addr %0d/%0d got %h/%h exp %h/%h", tag, a0, a1,
                     rd_data[0], rd_data[1], expect_rd(a0), expect_rd(a1));
        end
    endtask

    initial begin
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = 0; md[i] = 0; end
        for (int r = 0; r < REGS; r++) mem[r] = '0;
        #22 rst_n = 1'b1;
        @(negedge clk);
        // R1: everything zero after reset
        for (int r = 0; r < REGS; r += 2) chk(AW'(r), AW'(r + 1), "R1");

        // R2 forward next cycle, R9 two independent ports
        cyc(1, 3, 16'h1111, 0, 0);  chk(3, 2, "R2");
        cyc(1, 2, 16'h2222, 0, 0);  chk(2, 3, "R9");
        // R3 newest matching entry wins
        cyc(1, 3, 16'h3333, 0, 0);  chk(3, 3, "R3");
        // R5 undo one cycle, then two
        cyc(0, 0, 0, 1, 1);          chk(3, 2, "R5");
        cyc(1, 5, 16'h5555, 0, 0);
        cyc(1, 5, 16'h5656, 0, 0);
        cyc(0, 0, 0, 1, 2);          chk(5, 3, "R5");
        // R7 write dropped when rollback requested in same cycle
        cyc(1, 6, 16'h6666, 1, 0);   chk(6, 0, "R7");
        // R10 count 0 keeps earlier writes
        cyc(1, 4, 16'h4444, 0, 0);
        cyc(0, 0, 0, 1, 0);          chk(4, 3, "R10");
        // R8 write to register 0 has no effect
        cyc(1, 0, 16'hdead, 0, 0);   chk(0, 4, "R8");
        // R4 commit: idle N+1 cycles, full rollback must not remove it
        for (int k = 0; k < N + 1; k++) cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, N);          chk(4, 2, "R4");
        // R4 boundary: write exactly DEPTH cycles old is still revocable
        cyc(1, 7, 16'h7777, 0, 0);
        for (int k = 0; k < N - 1; k++) cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, N);          chk(7, 4, "R4");
        // R6 count above DEPTH saturates
        for (int k = 0; k < N; k++) cyc(1, AW'(k + 1), DW'(16'h8000 + k), 0, 0);
        cyc(0, 0, 0, 1, (1 << CW) - 1);
        chk(1, 2, "R6"); chk(3, 4, "R6");

        // random mix: R2 R3 R4 R5 R9
        for (int t = 0; t < 600; t++) begin
            bit we = ($urandom_range(0, 9) < 6);
            bit rb = ($urandom_range(0, 9) == 0);
            cyc(we, AW'($urandom_range(0, REGS - 1)), DW'($urandom), rb,
                $urandom_range(0, (1 << CW) - 1));
            chk(AW'($urandom_range(0, REGS - 1)), AW'($urandom_range(0, REGS - 1)), "R5 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule